// File: doc/BRIEF.md
# Three-Phase Rotation Classifier

This block decides the rotation direction of a three-phase supply from three square waves. Each wave comes from an external zero-crossing detector and is high during the positive half-cycle of its phase. After synchronisation to the local clock, a rising edge on any of the three lines is a capture event. At each capture the block records the present levels of all three lines as a 3-bit code.

Three consecutive codes make up one measuring cycle. The fourth capture closes the cycle. The block then checks that every code was legal, that the codes add up to fourteen, that the closing code repeats the first one, and that no two lines rose on the same clock. It reports the rotation with a one-cycle `done` strobe, and the `seq_neg` and `err` levels hold until the next strobe. The closing code also opens the next cycle, so a healthy supply yields a fresh decision every period. If no capture arrives within a programmable number of clocks, a watchdog ends the cycle with an error. This covers a dead phase.

Top module: `phase_seq_classifier`

## Requirements
- R1: The sampled code holds the synchronised R level in bit 0, Y in bit 1 and B in bit 2, and it is taken on the clock where any line shows a rising edge.
- R2: A cycle closes at its fourth capture. `done` is high for exactly one clock, in the third clock cycle after the input change that caused the closing edge.
- R3: The captured order 101, 011, 110, starting at any of the three, with a matching closing code, gives `done` with `seq_neg`=0 and `err`=0.
- R4: The reverse cyclic order 101, 110, 011, starting at any of the three, with a matching closing code, gives `done` with `seq_neg`=1 and `err`=0.
- R5: If the cycle contains a code other than 110, 101 or 011, or if the sum of its three codes is not 14, the cycle closes with `err`=1. Every erroneous decision reports `seq_neg`=0.
- R6: If the closing code differs from the first code of its cycle, the cycle still closes at the fourth capture, with `err`=1.
- R7: If two or more lines rise on the same clock in any capture of a cycle, that cycle closes with `err`=1.
- R8: If `timeout_limit` is non-zero and no capture occurs for `timeout_limit` consecutive clocks (counted from reset or from the last capture), `done` pulses with `err`=1 and the partial cycle is discarded. A value of 0 disables the timeout.
- R9: After reset `done`, `err` and `seq_neg` are 0. Between strobes, `err` and `seq_neg` hold their values.
- R10: The closing code is the first code of the next cycle, so a steady rotation yields a decision every three captures.
- R11: Levels already high when reset is released are not treated as rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_r | input | 1 | Square wave of phase R (asynchronous) |
| ph_y | input | 1 | Square wave of phase Y (asynchronous) |
| ph_b | input | 1 | Square wave of phase B (asynchronous) |
| timeout_limit | input | TMO_W | Clocks without a capture before the cycle is aborted; 0 disables |
| done | output | 1 | One-clock strobe when a decision is made |
| seq_neg | output | 1 | 0 = positive rotation, 1 = negative rotation |
| err | output | 1 | Last decision came from an invalid or aborted cycle |

## Verification
A wrong capture count or an off-by-one in the cycle position moves the `done` strobe to a different step. The bench samples in the exact third cycle after each input change, so such a fault shows at the first closing edge. If a code register, the running sum or the sticky fault flag goes wrong, `err` or `seq_neg` is wrong at that same strobe. The vectors cover both rotations from every starting code, and the error vectors set each fault cause one at a time. A fault in the watchdog shows as a timeout strobe on the wrong clock after reset, or as no strobe at all.

// File: rtl/phseq_pkg.sv
package phseq_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SUM_W  = 5;
  typedef logic [CODE_W-1:0] phcode_t;
  localparam logic [SUM_W-1:0] SUM_GOOD = SUM_W'(14);

  // Only codes with exactly two phases high are legal.
  function automatic logic code_legal(input phcode_t c);
    return (c == 3'b110) || (c == 3'b101) || (c == 3'b011);
  endfunction

  // Successor of a code in positive rotation: 101 -> 011 -> 110 -> 101.
  function automatic phcode_t next_fwd(input phcode_t c);
    case (c)
      3'b101:  return 3'b011;
      3'b011:  return 3'b110;
      3'b110:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [SUM_W-1:0] add_code(input logic [SUM_W-1:0] s, input phcode_t c);
    return s + {{(SUM_W-CODE_W){1'b0}}, c};
  endfunction

  function automatic logic is_fwd(input phcode_t a, input phcode_t b, input phcode_t c);
    return (b == next_fwd(a)) && (c == next_fwd(b));
  endfunction

  function automatic logic several(input phcode_t r);
    return (r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]);
  endfunction
endpackage

// File: rtl/phseq_edge_sync.sv
module phseq_edge_sync #(
  parameter int unsigned LINES       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise
);
  localparam int unsigned ARM_LEN = SYNC_STAGES + 1;

  logic [ARM_LEN-1:0] arm_sh;
  logic               armed;

  // Edge detection is held off until the sync chain and the delayed copy carry real input levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_sh <= '0;
    else        arm_sh <= {arm_sh[ARM_LEN-2:0], 1'b1};
  end
  assign armed = arm_sh[ARM_LEN-1];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[SYNC_STAGES-2:0], raw_in[g]};
        prev <= sh[SYNC_STAGES-1];
      end
    end
    assign level[g] = sh[SYNC_STAGES-1];
    assign rise[g]  = sh[SYNC_STAGES-1] & ~prev & armed;
  end
endmodule

// File: rtl/phseq_watchdog.sv
module phseq_watchdog #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = (limit != '0) && (cnt >= limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear || expire) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phseq_cycle_fsm.sv
module phseq_cycle_fsm
  import phseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    evt,
  input  logic    multi,
  input  phcode_t code,
  input  logic    expire,
  output logic    done,
  output logic    seq_neg,
  output logic    err
);
  logic [1:0]       nseen;
  phcode_t          c0, c1, c2;
  logic [SUM_W-1:0] sum;
  logic             bad;
  logic             code_bad;
  logic             close_bad;

  assign code_bad  = multi | ~code_legal(code);
  assign close_bad = bad | code_bad | (code != c0) | (sum != SUM_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nseen   <= '0;
      c0      <= '0;
      c1      <= '0;
      c2      <= '0;
      sum     <= '0;
      bad     <= 1'b0;
      done    <= 1'b0;
      seq_neg <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (evt) begin
        case (nseen)
          2'd0: begin
            c0 <= code; sum <= add_code('0, code); bad <= code_bad; nseen <= 2'd1;
          end
          2'd1: begin
            c1 <= code; sum <= add_code(sum, code); bad <= bad | code_bad; nseen <= 2'd2;
          end
          2'd2: begin
            c2 <= code; sum <= add_code(sum, code); bad <= bad | code_bad; nseen <= 2'd3;
          end
          default: begin
            done    <= 1'b1;
            err     <= close_bad;
            seq_neg <= ~close_bad & ~is_fwd(c0, c1, c2);
            // closing code opens the next cycle
            c0    <= code;
            sum   <= add_code('0, code);
            bad   <= code_bad;
            nseen <= 2'd1;
          end
        endcase
      end else if (expire) begin
        done    <= 1'b1;
        err     <= 1'b1;
        seq_neg <= 1'b0;
        bad     <= 1'b0;
        sum     <= '0;
        nseen   <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/phase_seq_classifier.sv
module phase_seq_classifier
  import phseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_r,
  input  logic             ph_y,
  input  logic             ph_b,
  input  logic [TMO_W-1:0] timeout_limit,
  output logic             done,
  output logic             seq_neg,
  output logic             err
);
  phcode_t raw_code;
  phcode_t cap_code;
  phcode_t rise;
  logic    evt;
  logic    multi;
  logic    expire;

  assign raw_code = {ph_b, ph_y, ph_r};

  phseq_edge_sync #(.LINES(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_code), .level(cap_code), .rise(rise)
  );

  assign evt   = |rise;
  assign multi = several(rise);

  phseq_watchdog #(.CNT_W(TMO_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .clear(evt), .limit(timeout_limit), .expire(expire)
  );

  phseq_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .evt(evt), .multi(multi), .code(cap_code),
    .expire(expire), .done(done), .seq_neg(seq_neg), .err(err)
  );
endmodule

// File: rtl/phseq_checker.sv
module phseq_checker
  import phseq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    evt,
  input logic    multi,
  input phcode_t cap_code,
  input logic    expire,
  input logic    done,
  input logic    seq_neg,
  input logic    err
);
  // R9: decision levels only move together with the strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(seq_neg) && $stable(err)));

  // R5: a clean decision follows a capture of a legal code
  p_clean_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(evt) && code_legal($past(cap_code))));

  // R7: a multi-edge closing capture never yields a clean decision
  p_multi_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && multi) |=> (!done || err));

  // R8: an expiry without a capture ends in an error strobe
  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !evt) |=> (done && err));

  // R4: negative rotation is reported only for a clean cycle
  p_neg_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && seq_neg) |-> !err);
endmodule

bind phase_seq_classifier phseq_checker u_phseq_checker (
  .clk(clk), .rst_n(rst_n), .evt(evt), .multi(multi), .cap_code(cap_code),
  .expire(expire), .done(done), .seq_neg(seq_neg), .err(err)
);

// File: tb/phase_seq_classifier_bench.sv
module phase_seq_classifier_bench;
  localparam int TMO_W = 24;
  localparam int NV    = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ph_r = 1'b0, ph_y = 1'b0, ph_b = 1'b0;
  logic [TMO_W-1:0] timeout_limit = TMO_W'(1000);
  logic             done, seq_neg, err;
  int               checks = 0;
  int               failures = 0;

  always #4 clk = ~clk;

  phase_seq_classifier #(.SYNC_STAGES(2), .TMO_W(TMO_W)) u_phase_seq_classifier (
    .clk(clk), .rst_n(rst_n), .ph_r(ph_r), .ph_y(ph_y), .ph_b(ph_b),
    .timeout_limit(timeout_limit), .done(done), .seq_neg(seq_neg), .err(err)
  );

  // {pre[3], nsteps[3], s0..s5 [3 each], exp_err, exp_seq}; code bit0=R, bit1=Y, bit2=B
  localparam logic [25:0] VEC [NV] = '{
    {3'b110, 3'd4, 3'b101, 3'b011, 3'b110, 3'b101, 3'b000, 3'b000, 1'b0, 1'b0}, // R3
    {3'b101, 3'd4, 3'b011, 3'b110, 3'b101, 3'b011, 3'b000, 3'b000, 1'b0, 1'b0}, // R3
    {3'b011, 3'd4, 3'b110, 3'b101, 3'b011, 3'b110, 3'b000, 3'b000, 1'b0, 1'b0}, // R3
    {3'b011, 3'd4, 3'b101, 3'b110, 3'b011, 3'b101, 3'b000, 3'b000, 1'b0, 1'b1}, // R4
    {3'b101, 3'd4, 3'b110, 3'b011, 3'b101, 3'b110, 3'b000, 3'b000, 1'b0, 1'b1}, // R4
    {3'b110, 3'd4, 3'b011, 3'b101, 3'b110, 3'b011, 3'b000, 3'b000, 1'b0, 1'b1}, // R4
    {3'b110, 3'd4, 3'b101, 3'b011, 3'b110, 3'b011, 3'b000, 3'b000, 1'b1, 1'b0}, // R6
    {3'b011, 3'd5, 3'b101, 3'b111, 3'b110, 3'b011, 3'b101, 3'b000, 1'b1, 1'b0}, // R5
    {3'b100, 3'd4, 3'b011, 3'b110, 3'b101, 3'b011, 3'b000, 3'b000, 1'b1, 1'b0}  // R7
  };

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input logic [2:0] c);
    ph_r = c[0]; ph_y = c[1]; ph_b = c[2];
  endtask

  task automatic do_reset(input logic [2:0] pre);
    @(negedge clk);
    rst_n = 1'b0;
    drive(pre);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // drive at a falling edge; the strobe is visible three falling edges later (R2)
  task automatic step(input logic [2:0] c, input logic exp_done, input string req);
    drive(c);
    repeat (3) @(negedge clk);
    chk(req, int'(done), int'(exp_done));
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n;
    int seen;
    // R9: reset state
    drive(3'b110);
    repeat (3) @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset err", int'(err), 0);
    chk("R9 reset seq_neg", int'(seq_neg), 0);

    // Vector table: R1 mapping, R2 latency, R3/R4 rotations, R5/R6/R7 faults, R11 startup
    for (int v = 0; v < NV; v++) begin
      logic [25:0] vec;
      vec = VEC[v];
      timeout_limit = TMO_W'(1000);
      do_reset(vec[25:23]);
      for (int i = 0; i < int'(vec[22:20]); i++) begin
        logic last;
        last = (i == int'(vec[22:20]) - 1);
        // R11: the preset level must not count as a capture, so no early strobe
        step(vec[19-3*i -: 3], last, last ? "R2 strobe at close" : "R11/R2 no early strobe");
        if (last) begin
          // checked after the hold: values stay put (R9)
          chk(vec[1] ? "R5/R6/R7 err" : "R3/R4 err", int'(err), int'(vec[1]));
          chk("R1/R3/R4 seq_neg", int'(seq_neg), int'(vec[0]));
        end
      end
    end

    // R10: continuous positive rotation gives a decision every three captures
    do_reset(3'b110);
    step(3'b101, 1'b0, "R10 cap1");
    step(3'b011, 1'b0, "R10 cap2");
    step(3'b110, 1'b0, "R10 cap3");
    step(3'b101, 1'b1, "R10 first close");
    step(3'b011, 1'b0, "R10 reopen");
    step(3'b110, 1'b0, "R10 mid");
    step(3'b101, 1'b1, "R10 second close");
    chk("R10 seq_neg", int'(seq_neg), 0);
    chk("R10 err", int'(err), 0);

    // R9: hold of a negative decision
    do_reset(3'b011);
    step(3'b101, 1'b0, "R9 a");
    step(3'b110, 1'b0, "R9 b");
    step(3'b011, 1'b0, "R9 c");
    step(3'b101, 1'b1, "R9 close");
    repeat (20) @(negedge clk);
    chk("R9 hold seq_neg", int'(seq_neg), 1);
    chk("R9 hold err", int'(err), 0);
    chk("R9 hold done", int'(done), 0);

    // R8: timeout from reset, exact cycle
    timeout_limit = TMO_W'(16);
    @(negedge clk);
    rst_n = 1'b0;
    drive(3'b110);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (done && n == 0) n = k;
    end
    chk("R8 timeout cycle", n, 16);
    chk("R8 timeout err", int'(err), 1);
    chk("R8 timeout seq_neg", int'(seq_neg), 0);

    // R8: limit of zero disables the timeout
    timeout_limit = '0;
    do_reset(3'b110);
    seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R8 disabled no strobe", seen, 0);

    // R8: missing phase in mid-cycle
    timeout_limit = TMO_W'(40);
    do_reset(3'b110);
    step(3'b101, 1'b0, "R8 mid cap1");
    step(3'b011, 1'b0, "R8 mid cap2");
    seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R8 mid abort strobes", seen, 2);
    chk("R8 mid abort err", int'(err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule